// File: doc/BRIEF.md
# Flash Embedded Status Bit Generator

This block sits on the device side of a NOR-style flash memory. It drives the byte that a host reads on the data bus while an embedded program or erase algorithm runs. It takes one-cycle command events from a command decoder: program, block erase, suspend, resume, write-buffer abort and return-to-read. It also takes done and timeout flags from the embedded algorithm, chip enable and output enable, and a read block address. From these it tracks the algorithm phase and the set of blocks being erased. For each read it decides whether the host sees a status byte or the array data presented on an input port.

A block erase opens an accept window that lasts a parameterised number of clock cycles. Each further block erase command inside the window adds a block and restarts the window. When the window runs out, the erase runs. Reads of a bank that holds busy blocks return status. Reads of other banks return array data. The toggle bits advance once per read strobe, not with time, so a host polling loop sees them change on every read.

Top module: `flash_status_gen`

## Requirements
- R1: An algorithm timeout during program or erase enters a failed phase. In that phase, status reads show bit 5 high. Only the return-to-read command leaves the failed phase, and it returns the block to idle.
- R2: Status bit 3 reads 0 while the erase accept window is open. The window covers WIN_CYC cycles after the latest block erase command. Bit 3 reads 1 while the erase runs, while the erase is suspended, and after an erase timeout. Bit 3 reads 0 for program.
- R3: erase_accept is high only while the window is open. A block erase command inside the window adds its block and restarts the window. While the erase runs, every command other than suspend has no effect.
- R4: During an erase, bit 2 inverts on each read strobe that addresses a bank holding an erasing block. After an erase timeout, bit 2 inverts only on strobes that address an erasing block itself.
- R5: In program suspend, reads of the programmed block return status. In erase suspend, reads of an erasing block return status. In both cases bit 2 inverts on each such strobe and bit 6 holds. Reads of other blocks return array_data.
- R6: Bit 6 inverts once per read strobe on status reads during program, the erase window, erase, the failed phase and the aborted phase. A read strobe is a falling oe_n while ce_n is low, or a falling ce_n while oe_n is low. Bit 6 does not change while a read is held.
- R7: Status bit 7 is the complement of program data bit 7 (cmd_d7) during program, program suspend and program timeout. Bit 7 is 0 during erase phases. Once the operation completes, reads return array_data.
- R8: A write-buffer abort from idle makes every read return status with bit 1 high. The state holds until the return-to-read command.
- R9: rdy equals the inverse of ce_n, so rdy is high whenever ce_n is low and oe_n is high.
- R10: In erase suspend, a program command to a block that is not erasing makes reads of that block return status with bit 2 high. A program command to an erasing block is ignored.
- R11: Banks are the top BANK_W bits of the block address. During program, erase or failure, reads outside the busy bank or banks return array_data.
- R12: dq is 0 when no read is active. After reset the block is idle, both toggle bits are 0, and reads return array_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_blk | input | BLK_W | Block address of the current read |
| array_data | input | 8 | Array contents at the read address |
| cmd_prog | input | 1 | Program command event |
| cmd_erase | input | 1 | Block erase command event |
| cmd_suspend | input | 1 | Suspend command event |
| cmd_resume | input | 1 | Resume command event |
| cmd_wb_abort | input | 1 | Write-buffer abort event |
| cmd_reset | input | 1 | Return-to-read command event |
| cmd_blk | input | BLK_W | Block address of the command |
| cmd_d7 | input | 1 | Bit 7 of the program data |
| op_done | input | 1 | Embedded algorithm finished |
| op_timeout | input | 1 | Embedded algorithm exceeded its time limit |
| dq | output | 8 | Status byte or array data |
| erase_accept | output | 1 | Further block erase commands accepted |
| rdy | output | 1 | Data ready |

## Verification
The assertions assume that command events are single-cycle pulses and that at most one event is raised in any cycle. They also assume op_done and op_timeout arrive only while an algorithm is running, and the read address is held steady for as long as a read is active. The stimulus drives each event for exactly one cycle through a task that clears it again. It changes rd_blk only between reads, and it raises done or timeout both inside and outside the running phases so that the ignoring paths are covered.

// File: rtl/flsb_pkg.sv
package flsb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_EWIN  = 3'd2,
    ST_ERASE = 3'd3,
    ST_ESUSP = 3'd4,
    ST_PSUSP = 3'd5,
    ST_FAIL  = 3'd6,
    ST_ABORT = 3'd7
  } flsb_st_e;

endpackage

// File: rtl/flsb_seq.sv
module flsb_seq
  import flsb_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int WIN_CYC = 10000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_prog,
  input  logic                   cmd_erase,
  input  logic                   cmd_suspend,
  input  logic                   cmd_resume,
  input  logic                   cmd_wb_abort,
  input  logic                   cmd_reset,
  input  logic [BLK_W-1:0]       cmd_blk,
  input  logic                   cmd_d7,
  input  logic                   op_done,
  input  logic                   op_timeout,
  output flsb_st_e               st,
  output logic [(1<<BLK_W)-1:0]  mask,
  output logic [BLK_W-1:0]       pblk,
  output logic                   pbit,
  output logic                   fail_erase,
  output logic                   sp_hit,
  output logic [BLK_W-1:0]       sp_blk,
  output logic                   sp_bit
);

  localparam int NBLK  = 1 << BLK_W;
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  flsb_st_e          st_q, st_d;
  logic [NBLK-1:0]   mask_q, mask_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BLK_W-1:0]  pblk_q, pblk_d, spblk_q, spblk_d;
  logic              pbit_q, pbit_d, fe_q, fe_d;
  logic              sph_q, sph_d, spbit_q, spbit_d;
  logic [NBLK-1:0]   blk_oh;
  logic              win_end;

  assign blk_oh  = NBLK'(1) << cmd_blk;
  assign win_end = (cnt_q == CNT_W'(WIN_CYC - 1));

  always_comb begin
    st_d    = st_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    pblk_d  = pblk_q;
    pbit_d  = pbit_q;
    fe_d    = fe_q;
    sph_d   = sph_q;
    spblk_d = spblk_q;
    spbit_d = spbit_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_prog) begin
          st_d   = ST_PROG;
          pblk_d = cmd_blk;
          pbit_d = cmd_d7;
        end else if (cmd_erase) begin
          st_d   = ST_EWIN;
          mask_d = blk_oh;
          cnt_d  = '0;
        end else if (cmd_wb_abort) begin
          st_d = ST_ABORT;
        end
      end
      ST_PROG: begin
        if (op_timeout) begin
          st_d = ST_FAIL;
          fe_d = 1'b0;
        end else if (op_done) begin
          st_d = ST_IDLE;
        end else if (cmd_suspend) begin
          st_d = ST_PSUSP;
        end
      end
      ST_EWIN: begin
        if (cmd_erase) begin
          mask_d = mask_q | blk_oh;
          cnt_d  = '0;
        end else if (win_end) begin
          st_d = ST_ERASE;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ERASE: begin
        if (op_timeout) begin
          st_d = ST_FAIL;
          fe_d = 1'b1;
        end else if (op_done) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end else if (cmd_suspend) begin
          st_d = ST_ESUSP;
        end
      end
      ST_ESUSP: begin
        if (cmd_resume) begin
          st_d  = ST_ERASE;
          sph_d = 1'b0;
        end else if (cmd_prog && ((mask_q & blk_oh) == '0)) begin
          sph_d   = 1'b1;
          spblk_d = cmd_blk;
          spbit_d = cmd_d7;
        end
      end
      ST_PSUSP: begin
        if (cmd_resume) st_d = ST_PROG;
      end
      ST_FAIL: begin
        if (cmd_reset) begin
          st_d   = ST_IDLE;
          mask_d = '0;
        end
      end
      ST_ABORT: begin
        if (cmd_reset) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      cnt_q   <= '0;
      pblk_q  <= '0;
      pbit_q  <= 1'b0;
      fe_q    <= 1'b0;
      sph_q   <= 1'b0;
      spblk_q <= '0;
      spbit_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
      pblk_q  <= pblk_d;
      pbit_q  <= pbit_d;
      fe_q    <= fe_d;
      sph_q   <= sph_d;
      spblk_q <= spblk_d;
      spbit_q <= spbit_d;
    end
  end

  assign st         = st_q;
  assign mask       = mask_q;
  assign pblk       = pblk_q;
  assign pbit       = pbit_q;
  assign fail_erase = fe_q;
  assign sp_hit     = sph_q;
  assign sp_blk     = spblk_q;
  assign sp_bit     = spbit_q;

  // R1: the failed phase is left only through return-to-read
  p_fail_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && !cmd_reset) |=> (st_q == ST_FAIL));

  // R3: an erase command inside the window restarts it
  p_window_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EWIN && cmd_erase) |=> (st_q == ST_EWIN && cnt_q == '0));

  // R3: the erasing set is frozen once the erase runs
  p_erase_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERASE && !op_done) |=> $stable(mask_q));

endmodule

// File: rtl/flsb_route.sv
module flsb_route
  import flsb_pkg::*;
#(
  parameter int BLK_W  = 4,
  parameter int BANK_W = 2
) (
  input  flsb_st_e              st,
  input  logic [(1<<BLK_W)-1:0] mask,
  input  logic [BLK_W-1:0]      pblk,
  input  logic                  pbit,
  input  logic                  fail_erase,
  input  logic                  sp_hit,
  input  logic [BLK_W-1:0]      sp_blk,
  input  logic                  sp_bit,
  input  logic [BLK_W-1:0]      rd_blk,
  output logic                  stat_rd,
  output logic                  sp_rd,
  output logic                  t6_en,
  output logic                  t2_en,
  output logic                  b7,
  output logic                  b3
);

  localparam int NBANK = 1 << BANK_W;
  localparam int BPB   = (1 << BLK_W) / NBANK;

  logic [NBANK-1:0]  bank_busy;
  logic [BANK_W-1:0] rd_bank, p_bank;
  logic              ebank_hit, pbank_hit, in_mask;

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    assign bank_busy[gb] = |mask[gb*BPB +: BPB];
  end

  assign rd_bank   = rd_blk[BLK_W-1 -: BANK_W];
  assign p_bank    = pblk[BLK_W-1 -: BANK_W];
  assign ebank_hit = bank_busy[rd_bank];
  assign pbank_hit = (rd_bank == p_bank);
  assign in_mask   = mask[rd_blk];

  always_comb begin
    stat_rd = 1'b0;
    sp_rd   = 1'b0;
    t6_en   = 1'b0;
    t2_en   = 1'b0;
    b7      = 1'b0;
    b3      = 1'b0;
    case (st)
      ST_PROG: begin
        stat_rd = pbank_hit;
        t6_en   = pbank_hit;
        b7      = ~pbit;
      end
      ST_EWIN: begin
        stat_rd = ebank_hit;
        t6_en   = ebank_hit;
        t2_en   = ebank_hit;
      end
      ST_ERASE: begin
        stat_rd = ebank_hit;
        t6_en   = ebank_hit;
        t2_en   = ebank_hit;
        b3      = 1'b1;
      end
      ST_FAIL: begin
        stat_rd = fail_erase ? ebank_hit : pbank_hit;
        t6_en   = stat_rd;
        t2_en   = fail_erase & in_mask;
        b7      = ~fail_erase & ~pbit;
        b3      = fail_erase;
      end
      ST_ABORT: begin
        stat_rd = 1'b1;
        t6_en   = 1'b1;
      end
      ST_PSUSP: begin
        stat_rd = (rd_blk == pblk);
        t2_en   = stat_rd;
        b7      = ~pbit;
      end
      ST_ESUSP: begin
        sp_rd   = sp_hit & (rd_blk == sp_blk) & ~in_mask;
        stat_rd = in_mask | sp_rd;
        t2_en   = in_mask;
        b7      = sp_rd & ~sp_bit;
        b3      = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flsb_toggle.sv
module flsb_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_act,
  input  logic t6_en,
  input  logic t2_en,
  output logic t6,
  output logic t2
);

  logic rd_q, t6_q, t2_q;
  logic strobe, t6_d, t2_d;

  assign strobe = rd_act & ~rd_q;
  assign t6_d   = t6_q ^ (strobe & t6_en);
  assign t2_d   = t2_q ^ (strobe & t2_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      t6_q <= t6_d;
      t2_q <= t2_d;
    end
  end

  assign t6 = t6_q;
  assign t2 = t2_q;

  // R6: toggle bits move only on a read strobe
  p_toggle_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(t6_q) && $stable(t2_q)));

  // R6: one strobe per read, however long it is held
  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flsb_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int BANK_W  = 2,
  parameter int WIN_CYC = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic [BLK_W-1:0] rd_blk,
  input  logic [7:0]       array_data,
  input  logic             cmd_prog,
  input  logic             cmd_erase,
  input  logic             cmd_suspend,
  input  logic             cmd_resume,
  input  logic             cmd_wb_abort,
  input  logic             cmd_reset,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             cmd_d7,
  input  logic             op_done,
  input  logic             op_timeout,
  output logic [7:0]       dq,
  output logic             erase_accept,
  output logic             rdy
);

  localparam int NBLK = 1 << BLK_W;

  logic             rs1_q, rs2_q, rst_i;
  flsb_st_e         st;
  logic [NBLK-1:0]  mask;
  logic [BLK_W-1:0] pblk, sp_blk;
  logic             pbit, fe, sp_hit, sp_bit;
  logic             stat_rd, sp_rd, t6_en, t2_en, b7, b3;
  logic             t6, t2, rd_act;
  logic [7:0]       status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_i = rs2_q;

  assign rd_act = ~ce_n & ~oe_n;

  flsb_seq #(.BLK_W(BLK_W), .WIN_CYC(WIN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_suspend(cmd_suspend),
    .cmd_resume(cmd_resume), .cmd_wb_abort(cmd_wb_abort), .cmd_reset(cmd_reset),
    .cmd_blk(cmd_blk), .cmd_d7(cmd_d7), .op_done(op_done), .op_timeout(op_timeout),
    .st(st), .mask(mask), .pblk(pblk), .pbit(pbit), .fail_erase(fe),
    .sp_hit(sp_hit), .sp_blk(sp_blk), .sp_bit(sp_bit)
  );

  flsb_route #(.BLK_W(BLK_W), .BANK_W(BANK_W)) u_route (
    .st(st), .mask(mask), .pblk(pblk), .pbit(pbit), .fail_erase(fe),
    .sp_hit(sp_hit), .sp_blk(sp_blk), .sp_bit(sp_bit), .rd_blk(rd_blk),
    .stat_rd(stat_rd), .sp_rd(sp_rd), .t6_en(t6_en), .t2_en(t2_en),
    .b7(b7), .b3(b3)
  );

  flsb_toggle u_tog (
    .clk(clk), .rst_n(rst_i), .rd_act(rd_act),
    .t6_en(t6_en), .t2_en(t2_en), .t6(t6), .t2(t2)
  );

  assign status = {b7, t6, (st == ST_FAIL), 1'b0, b3, (sp_rd | t2),
                   (st == ST_ABORT), 1'b0};

  always_comb begin
    if (!rd_act)      dq = 8'h00;
    else if (stat_rd) dq = status;
    else              dq = array_data;
  end

  assign erase_accept = (st == ST_EWIN);
  assign rdy          = ~ce_n;

  // R8: an aborted buffer write shows bit 1 on every read
  p_abort_dq1_r8: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_ABORT && rd_act) |-> dq[1]);

  // R1: failure status carries bit 5
  p_fail_dq5_r1: assert property (@(posedge clk) disable iff (!rst_i)
    (st == ST_FAIL && rd_act && stat_rd) |-> dq[5]);

  // R3: the accept window closes only into the running erase
  p_accept_end_r3: assert property (@(posedge clk) disable iff (!rst_i)
    erase_accept |=> (erase_accept || st == ST_ERASE));

endmodule

// File: tb/sim_flash_status_gen.sv
`timescale 1ns/100ps
module sim_flash_status_gen;

  localparam int BW  = 4;
  localparam int WIN = 16;
  localparam int K_PROG = 0, K_ERASE = 1, K_SUSP = 2, K_RES = 3,
                 K_ABORT = 4, K_RESET = 5, K_DONE = 6, K_TMO = 7;
  localparam int M_IDLE = 0, M_PROG = 1, M_EWIN = 2, M_ERASE = 3,
                 M_ESUSP = 4, M_PSUSP = 5, M_FAIL = 6, M_ABORT = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1;
  logic [BW-1:0] rd_blk = '0, cmd_blk = '0;
  logic [7:0] array_data;
  logic [7:0] aseed = 8'h5a;
  logic cmd_prog = 0, cmd_erase = 0, cmd_suspend = 0, cmd_resume = 0;
  logic cmd_wb_abort = 0, cmd_reset = 0, cmd_d7 = 0, op_done = 0, op_timeout = 0;
  logic [7:0] dq;
  logic erase_accept, rdy;

  int nvec = 0, nfail = 0;
  bit cmp_en = 0, finished = 0;

  always #2.5 clk = ~clk;
  assign array_data = 8'(rd_blk * 37) ^ aseed;

  flash_status_gen #(.BLK_W(BW), .BANK_W(2), .WIN_CYC(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .rd_blk(rd_blk),
    .array_data(array_data), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
    .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
    .cmd_wb_abort(cmd_wb_abort), .cmd_reset(cmd_reset), .cmd_blk(cmd_blk),
    .cmd_d7(cmd_d7), .op_done(op_done), .op_timeout(op_timeout),
    .dq(dq), .erase_accept(erase_accept), .rdy(rdy)
  );

  // behavioural reference model
  int mst, mcnt, mpblk, mspblk, msync;
  bit mmask [16];
  bit mpbit, mfe, msph, mspbit, mt6, mt2, mrq;

  function automatic bit busy_bank(input int bk);
    for (int i = 0; i < 16; i++) if (mmask[i] && (i / 4) == bk) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void classify(input int rb, output bit stat, output bit sp,
                                   output bit e6, output bit e2);
    stat = 0; sp = 0; e6 = 0; e2 = 0;
    case (mst)
      M_PROG:  begin stat = (rb / 4 == mpblk / 4); e6 = stat; end
      M_EWIN, M_ERASE: begin stat = busy_bank(rb / 4); e6 = stat; e2 = stat; end
      M_FAIL:  begin
        stat = mfe ? busy_bank(rb / 4) : (rb / 4 == mpblk / 4);
        e6 = stat; e2 = mfe && mmask[rb];
      end
      M_ABORT: begin stat = 1; e6 = 1; end
      M_PSUSP: begin stat = (rb == mpblk); e2 = stat; end
      M_ESUSP: begin
        sp = msph && rb == mspblk && !mmask[rb];
        stat = mmask[rb] || sp; e2 = mmask[rb];
      end
      default: ;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = M_IDLE; mcnt = 0; mpblk = 0; mspblk = 0; msync = 0;
      mpbit = 0; mfe = 0; msph = 0; mspbit = 0; mt6 = 0; mt2 = 0; mrq = 0;
      for (int i = 0; i < 16; i++) mmask[i] = 0;
    end else if (msync < 2) begin
      msync++;
    end else begin
      bit ract, stb, st_r, sp_r, e6, e2;
      int cb;
      ract = !ce_n && !oe_n;
      stb = ract && !mrq;
      mrq = ract;
      classify(int'(rd_blk), st_r, sp_r, e6, e2);
      if (stb && e6) mt6 = !mt6;
      if (stb && e2) mt2 = !mt2;
      cb = int'(cmd_blk);
      case (mst)
        M_IDLE: if (cmd_prog) begin mst = M_PROG; mpblk = cb; mpbit = cmd_d7; end
                else if (cmd_erase) begin
                  for (int i = 0; i < 16; i++) mmask[i] = (i == cb);
                  mcnt = 0; mst = M_EWIN;
                end else if (cmd_wb_abort) mst = M_ABORT;
        M_PROG: if (op_timeout) begin mst = M_FAIL; mfe = 0; end
                else if (op_done) mst = M_IDLE;
                else if (cmd_suspend) mst = M_PSUSP;
        M_EWIN: if (cmd_erase) begin mmask[cb] = 1; mcnt = 0; end
                else if (mcnt == WIN - 1) mst = M_ERASE;
                else mcnt++;
        M_ERASE: if (op_timeout) begin mst = M_FAIL; mfe = 1; end
                 else if (op_done) begin
                   mst = M_IDLE;
                   for (int i = 0; i < 16; i++) mmask[i] = 0;
                 end else if (cmd_suspend) mst = M_ESUSP;
        M_ESUSP: if (cmd_resume) begin mst = M_ERASE; msph = 0; end
                 else if (cmd_prog && !mmask[cb]) begin
                   msph = 1; mspblk = cb; mspbit = cmd_d7;
                 end
        M_PSUSP: if (cmd_resume) mst = M_PROG;
        M_FAIL:  if (cmd_reset) begin
                   mst = M_IDLE;
                   for (int i = 0; i < 16; i++) mmask[i] = 0;
                 end
        M_ABORT: if (cmd_reset) mst = M_IDLE;
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      bit st_r, sp_r, e6, e2;
      logic [7:0] e;
      classify(int'(rd_blk), st_r, sp_r, e6, e2);
      check("R9 rdy", {7'd0, rdy}, {7'd0, !ce_n});
      check("R3 erase_accept", {7'd0, erase_accept}, {7'd0, mst == M_EWIN});
      if (ce_n || oe_n) check("R12 idle bus", dq, 8'h00);
      else if (!st_r) check((mst == M_IDLE) ? "R7 array data" : "R11 array data",
                            dq, array_data);
      else begin
        e[7] = (mst == M_PROG || mst == M_PSUSP || (mst == M_FAIL && !mfe)) ? !mpbit :
               (mst == M_ESUSP && sp_r) ? !mspbit : 1'b0;
        e[6] = mt6;
        e[5] = (mst == M_FAIL);
        e[4] = 0;
        e[3] = (mst == M_ERASE || mst == M_ESUSP || (mst == M_FAIL && mfe));
        e[2] = sp_r ? 1'b1 : mt2;
        e[1] = (mst == M_ABORT);
        e[0] = 0;
        check("R7 dq7", {7'd0, dq[7]}, {7'd0, e[7]});
        check("R6 dq6", {7'd0, dq[6]}, {7'd0, e[6]});
        check("R1 dq5", {7'd0, dq[5]}, {7'd0, e[5]});
        check("R2 dq3", {7'd0, dq[3]}, {7'd0, e[3]});
        check(sp_r ? "R10 dq2" : (mst == M_ESUSP || mst == M_PSUSP) ? "R5 dq2" : "R4 dq2",
              {7'd0, dq[2]}, {7'd0, e[2]});
        check("R8 dq1", {7'd0, dq[1]}, {7'd0, e[1]});
        check("R12 fixed bits", {6'd0, dq[4], dq[0]}, 8'h00);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input int k, input int blk, input bit d7);
    @(posedge clk); #1;
    cmd_blk = BW'(blk); cmd_d7 = d7;
    case (k)
      K_PROG:  cmd_prog = 1;
      K_ERASE: cmd_erase = 1;
      K_SUSP:  cmd_suspend = 1;
      K_RES:   cmd_resume = 1;
      K_ABORT: cmd_wb_abort = 1;
      K_RESET: cmd_reset = 1;
      K_DONE:  op_done = 1;
      default: op_timeout = 1;
    endcase
    @(posedge clk); #1;
    cmd_prog = 0; cmd_erase = 0; cmd_suspend = 0; cmd_resume = 0;
    cmd_wb_abort = 0; cmd_reset = 0; op_done = 0; op_timeout = 0;
  endtask

  // one read of n cycles, strobed by oe_n or by ce_n
  task automatic rd(input int blk, input int n, input bit via_ce);
    @(posedge clk); #1;
    rd_blk = BW'(blk);
    aseed = aseed + 8'h13;
    if (via_ce) begin
      ce_n = 1; oe_n = 0;
      wait_cyc(1);
      ce_n = 0;
    end else oe_n = 0;
    wait_cyc(n);
    oe_n = 1;
    wait_cyc(1);
  endtask

  initial begin
    wait_cyc(2);
    cmp_en = 1;
    wait_cyc(2);
    rst_n = 1;
    wait_cyc(4);
    ce_n = 0;
    rd(3, 2, 0); rd(10, 3, 1);
    // program with bank routing and suspend
    issue(K_PROG, 5, 1);
    rd(6, 3, 0); rd(6, 1, 0); rd(5, 2, 1); rd(13, 2, 0);
    wait_cyc(3);
    issue(K_SUSP, 0, 0);
    rd(5, 2, 0); rd(5, 2, 0); rd(6, 2, 0);
    issue(K_RES, 0, 0);
    rd(4, 2, 0);
    issue(K_DONE, 0, 0);
    rd(5, 2, 0);
    // multi-block erase window
    issue(K_ERASE, 2, 0);
    rd(1, 3, 0);
    wait_cyc(6);
    issue(K_ERASE, 9, 0);
    rd(8, 2, 0);
    issue(K_PROG, 7, 1);
    wait_cyc(WIN + 4);
    rd(0, 2, 0); rd(10, 2, 0); rd(14, 2, 0);
    issue(K_ERASE, 14, 0);
    issue(K_PROG, 14, 1);
    issue(K_RES, 0, 0);
    rd(14, 2, 0);
    // erase suspend
    issue(K_SUSP, 0, 0);
    rd(2, 2, 0); rd(2, 2, 0); rd(3, 2, 0);
    issue(K_PROG, 3, 0);
    rd(3, 2, 0);
    issue(K_PROG, 2, 1);
    rd(9, 2, 0); rd(2, 2, 1);
    issue(K_RES, 0, 0);
    rd(3, 2, 0);
    // erase timeout
    issue(K_TMO, 0, 0);
    rd(2, 2, 0); rd(0, 2, 0); rd(9, 2, 0); rd(12, 2, 0);
    issue(K_DONE, 0, 0);
    rd(2, 2, 0);
    issue(K_RESET, 0, 0);
    rd(2, 2, 0);
    // program timeout
    issue(K_PROG, 12, 0);
    rd(13, 2, 0);
    issue(K_TMO, 0, 0);
    rd(15, 2, 1); rd(1, 2, 0);
    issue(K_RESET, 0, 0);
    // erase that completes
    issue(K_ERASE, 15, 0);
    wait_cyc(WIN + 2);
    rd(12, 2, 0);
    issue(K_DONE, 0, 0);
    rd(15, 2, 0);
    // write-buffer abort
    issue(K_ABORT, 0, 0);
    rd(0, 2, 0); rd(11, 2, 0);
    issue(K_RES, 0, 0);
    rd(11, 1, 0);
    issue(K_RESET, 0, 0);
    rd(0, 2, 0);
    ce_n = 1;
    wait_cyc(3);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule